// File: doc/BRIEF.md
# GPIO Port Interrupt Unit

This unit watches three 8-bit input ports (A, B and F) and turns pin activity into interrupt requests. Every pin is configured on its own: level or edge sensitivity, active polarity, an enable, and an optional input filter that rejects short glitches. Edge events are held in sticky latches until software acknowledges them. Level conditions are never latched and follow the pin directly.

Software reaches the configuration and status through a small synchronous byte-wide register port. Writes take effect at the clock edge. Reads are combinational from the address. Ports A and B combine their pending bits onto one shared request line. Each of the eight port F pins drives a request line of its own, so a handler can tell which pin fired without reading status.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every configuration register, every edge latch and every status bit is 0, and `irq_ab` and `irq_f` are low.
- R2: Each port occupies six byte addresses from its base (A 0x90, B 0xAC, F 0x4C): base+0x00 mode, +0x04 polarity, +0x08 acknowledge (write-only, reads 0), +0x0C enable, +0x10 status (read-only), +0x18 filter enable. Mode, polarity, enable and filter registers read back what was written.
- R3: A pin whose mode bit is 0 is level-sensitive. Its status bit is 1 while it is enabled and its synchronised level equals its polarity bit (1 = high, 0 = low).
- R4: A pin whose mode bit is 1 is edge-sensitive. A rising edge (polarity 1) or falling edge (polarity 0) sets its latch, and the status bit stays 1 after the pin returns, including on the opposite edge.
- R5: Writing the acknowledge register clears the latch of each pin written as 1. Bits written as 0 leave their latches unchanged.
- R6: Changing mode or polarity while the pins are steady sets no latch.
- R7: A disabled pin shows 0 in status and on its request line, but its latch is kept and appears again when the pin is re-enabled.
- R8: With a pin's filter bit set, a new level is accepted only after 4 consecutive identical samples, so a 3-cycle pulse is ignored and an 8-cycle pulse is seen. With the bit clear, a 1-cycle pulse is enough to set an edge latch.
- R9: `irq_ab` is the OR of all status bits of ports A and B. Bit i of `irq_f` is status bit i of port F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (0 for unmapped or write-only) |
| pin_a | input | 8 | Port A pins (asynchronous) |
| pin_b | input | 8 | Port B pins (asynchronous) |
| pin_f | input | 8 | Port F pins (asynchronous) |
| irq_ab | output | 1 | Shared request of ports A and B |
| irq_f | output | 8 | Per-pin requests of port F |

## Verification
On every cycle, the assertions check that a disabled pin never drives a request line and that the reset state is quiet. When the pins have been steady long enough, they also check that a port F level pin's request equals its pin compared against polarity, and that a full acknowledge of an all-edge port F clears every request. Only the directed scenarios can show the sticky behaviour across opposite edges, the register readback, the selective acknowledge, the latch kept under masking, and the glitch filter's 3-versus-8-cycle pulse decision.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

    localparam int ADDR_W   = 8;
    localparam int NUM_PORT = 3;

    // register slots inside one port window
    typedef enum logic [2:0] {
        REG_NONE,
        REG_MODE,
        REG_POL,
        REG_ACK,
        REG_EN,
        REG_STAT,
        REG_FILT
    } reg_sel_e;

    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_POL  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ACK  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_EN   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_FILT = 8'h18;

    // port index 0 = A, 1 = B, 2 = F
    function automatic logic [ADDR_W-1:0] port_base(input int idx);
        case (idx)
            0:       return 8'h90;
            1:       return 8'hAC;
            default: return 8'h4C;
        endcase
    endfunction

    function automatic reg_sel_e decode_slot(input logic [ADDR_W-1:0] addr,
                                             input logic [ADDR_W-1:0] base);
        logic [ADDR_W-1:0] ofs;
        ofs = addr - base;
        case (ofs)
            OFS_MODE: return REG_MODE;
            OFS_POL:  return REG_POL;
            OFS_ACK:  return REG_ACK;
            OFS_EN:   return REG_EN;
            OFS_STAT: return REG_STAT;
            OFS_FILT: return REG_FILT;
            default:  return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_pin_filter.sv
`timescale 1ns/1ps
module gpio_pin_filter #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DB_LEN      = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] filt_en_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    localparam int CNT_W = (DB_LEN > 2) ? $clog2(DB_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_LEN - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0][W-1:0] sync;
        logic [W-1:0]                  lvl;
        logic [W-1:0]                  prev;
        logic [W-1:0][CNT_W-1:0]       cnt;
    } flt_state_t;

    flt_state_t state_d, state_q;
    logic [W-1:0] smp;

    always_comb begin
        state_d         = state_q;
        state_d.sync[0] = pin_i;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            state_d.sync[s] = state_q.sync[s-1];
        end
        smp          = state_q.sync[SYNC_STAGES-1];
        state_d.prev = state_q.lvl;
        for (int i = 0; i < W; i++) begin
            if (!filt_en_i[i]) begin
                state_d.lvl[i] = smp[i];
                state_d.cnt[i] = '0;
            end else if (smp[i] == state_q.lvl[i]) begin
                state_d.cnt[i] = '0;
            end else if (state_q.cnt[i] == CNT_LAST) begin
                state_d.lvl[i] = smp[i];
                state_d.cnt[i] = '0;
            end else begin
                state_d.cnt[i] = state_q.cnt[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign lvl_o  = state_q.lvl;
    assign prev_o = state_q.prev;

endmodule

// File: rtl/gpio_port_bank.sv
`timescale 1ns/1ps
module gpio_port_bank
    import gpio_irq_pkg::*;
#(
    parameter int                W           = 8,
    parameter logic [ADDR_W-1:0] BASE        = 8'h90,
    parameter int                SYNC_STAGES = 2,
    parameter int                DB_LEN      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      pin_i,
    output logic              rd_hit_o,
    output logic [W-1:0]      rd_data_o,
    output logic [W-1:0]      status_o
);
    typedef struct packed {
        logic [W-1:0] mode;
        logic [W-1:0] pol;
        logic [W-1:0] en;
        logic [W-1:0] filt;
        logic [W-1:0] latch;
    } bank_state_t;

    bank_state_t state_d, state_q;
    reg_sel_e    sel;
    logic [W-1:0] lvl, prv, edge_hit, ack_mask, level_hit, stat;

    gpio_pin_filter #(
        .W           (W),
        .SYNC_STAGES (SYNC_STAGES),
        .DB_LEN      (DB_LEN)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .filt_en_i (state_q.filt),
        .lvl_o     (lvl),
        .prev_o    (prv)
    );

    always_comb begin
        state_d   = state_q;
        rd_data_o = '0;
        sel       = decode_slot(bus_addr, BASE);

        // polarity 1 picks rising, 0 picks falling
        edge_hit  = (lvl & ~prv & state_q.pol) | (~lvl & prv & ~state_q.pol);
        ack_mask  = (bus_wr && sel == REG_ACK) ? bus_wdata : '0;
        // a fresh event wins over a simultaneous acknowledge
        state_d.latch = (state_q.latch & ~ack_mask) | (edge_hit & state_q.mode);

        if (bus_wr) begin
            case (sel)
                REG_MODE: state_d.mode = bus_wdata;
                REG_POL:  state_d.pol  = bus_wdata;
                REG_EN:   state_d.en   = bus_wdata;
                REG_FILT: state_d.filt = bus_wdata;
                default:  ;
            endcase
        end

        level_hit = ~(lvl ^ state_q.pol);
        stat      = state_q.en & ((state_q.mode & state_q.latch) |
                                  (~state_q.mode & level_hit));

        case (sel)
            REG_MODE: rd_data_o = state_q.mode;
            REG_POL:  rd_data_o = state_q.pol;
            REG_EN:   rd_data_o = state_q.en;
            REG_FILT: rd_data_o = state_q.filt;
            REG_STAT: rd_data_o = stat;
            default:  rd_data_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rd_hit_o = (sel != REG_NONE);
    assign status_o = stat;

endmodule

// File: rtl/gpio_irq_unit.sv
`timescale 1ns/1ps
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DB_LEN      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_a,
    input  logic [W-1:0]      pin_b,
    input  logic [W-1:0]      pin_f,
    output logic              irq_ab,
    output logic [W-1:0]      irq_f
);
    logic [NUM_PORT-1:0][W-1:0] pins;
    logic [NUM_PORT-1:0][W-1:0] stat;
    logic [NUM_PORT-1:0][W-1:0] rdv;
    logic [NUM_PORT-1:0]        hit;

    assign pins = {pin_f, pin_b, pin_a};

    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        gpio_port_bank #(
            .W           (W),
            .BASE        (port_base(p)),
            .SYNC_STAGES (SYNC_STAGES),
            .DB_LEN      (DB_LEN)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_addr  (bus_addr),
            .bus_wr    (bus_wr),
            .bus_wdata (bus_wdata),
            .pin_i     (pins[p]),
            .rd_hit_o  (hit[p]),
            .rd_data_o (rdv[p]),
            .status_o  (stat[p])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORT; p++) begin
            if (hit[p]) bus_rdata = bus_rdata | rdv[p];
        end
    end

    assign irq_ab = (|stat[0]) | (|stat[1]);
    assign irq_f  = stat[2];

endmodule

// File: rtl/gpio_irq_unit_chk.sv
`timescale 1ns/1ps
module gpio_irq_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] pin_a,
    input logic [7:0] pin_b,
    input logic [7:0] pin_f,
    input logic       irq_ab,
    input logic [7:0] irq_f
);
    // shadows of configuration, rebuilt from bus writes
    logic [7:0] en_a, en_b, en_f, mode_f, pol_f, filt_f;
    logic [2:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_a <= '0; en_b <= '0; en_f <= '0;
            mode_f <= '0; pol_f <= '0; filt_f <= '0;
            since_rst <= '0;
        end else begin
            if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
            if (bus_wr) begin
                case (bus_addr)
                    8'h9C: en_a   <= bus_wdata;
                    8'hB8: en_b   <= bus_wdata;
                    8'h58: en_f   <= bus_wdata;
                    8'h4C: mode_f <= bus_wdata;
                    8'h50: pol_f  <= bus_wdata;
                    8'h64: filt_f <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // R1: quiet outputs when reset is released
    p_quiet_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_ab == 1'b0 && irq_f == 8'h00));

    // R7: disabled F pins never request
    p_mask_f_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_f & ~en_f) == 8'h00);

    // R7, R9: shared line silent while A and B are fully disabled
    p_mask_ab_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a == 8'h00 && en_b == 8'h00) |-> !irq_ab);

    // R3: steady level pins on port F follow pin versus polarity
    p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && mode_f == 8'h00 && filt_f == 8'h00 && en_f == 8'hFF &&
         $stable(pin_f) && $past(pin_f) == $past(pin_f, 2) &&
         $past(pin_f, 2) == $past(pin_f, 3))
        |-> (irq_f == ~(pin_f ^ pol_f)));

    // R5: full acknowledge of an all-edge, steady port F clears every request
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd5 && bus_wr && bus_addr == 8'h54 && bus_wdata == 8'hFF &&
         mode_f == 8'hFF && filt_f == 8'h00 &&
         $stable(pin_f) && $past(pin_f) == $past(pin_f, 2) &&
         $past(pin_f, 2) == $past(pin_f, 3) && $past(pin_f, 3) == $past(pin_f, 4))
        |=> (irq_f == 8'h00));

endmodule

bind gpio_irq_unit gpio_irq_unit_chk u_chk (.*);

// File: tb/sim_gpio_irq_unit.sv
`timescale 1ns/1ps
module sim_gpio_irq_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_a = '0, pin_b = '0, pin_f = '0;
    logic       irq_ab;
    logic [7:0] irq_f;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_a(pin_a),
        .pin_b(pin_b), .pin_f(pin_f), .irq_ab(irq_ab), .irq_f(irq_f)
    );

    localparam logic [7:0] A = 8'h90, B = 8'hAC, F = 8'h4C;
    localparam logic [7:0] MODE = 8'h00, POL = 8'h04, ACK = 8'h08,
                           EN = 8'h0C, STAT = 8'h10, FILT = 8'h18;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] addr, input logic [7:0] data);
        @(negedge clk);
        bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] addr, output logic [7:0] data);
        bus_addr = addr;
        #0.5;
        data = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet_all();
        wr(A + EN, 8'h00); wr(B + EN, 8'h00); wr(F + EN, 8'h00);
        wr(A + ACK, 8'hFF); wr(B + ACK, 8'hFF); wr(F + ACK, 8'hFF);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        settle(1);
        rd(A + MODE, v); chk("R1 A mode", v, 8'h00);
        rd(F + FILT, v); chk("R1 F filter", v, 8'h00);
        rd(B + STAT, v); chk("R1 B status", v, 8'h00);
        chk("R1 irq_ab", {7'd0, irq_ab}, 8'h00);
        chk("R1 irq_f", irq_f, 8'h00);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        wr(A + MODE, 8'h5A); wr(B + POL, 8'hC3);
        wr(F + EN, 8'h81);   wr(F + FILT, 8'h3C);
        rd(A + MODE, v); chk("R2 A mode readback", v, 8'h5A);
        rd(B + POL, v);  chk("R2 B polarity readback", v, 8'hC3);
        rd(F + EN, v);   chk("R2 F enable readback", v, 8'h81);
        rd(F + FILT, v); chk("R2 F filter readback", v, 8'h3C);
        rd(F + ACK, v);  chk("R2 ack reads zero", v, 8'h00);
        wr(A + MODE, 8'h00); wr(B + POL, 8'h00);
        wr(F + EN, 8'h00);   wr(F + FILT, 8'h00);
    endtask

    task automatic t_level();
        logic [7:0] v;
        wr(F + MODE, 8'h00); wr(F + POL, 8'h0F); wr(F + EN, 8'hFF);
        @(negedge clk); pin_f = 8'h05;
        settle(6);
        rd(F + STAT, v); chk("R3 level status", v, 8'hF5);
        chk("R3 level irq_f", irq_f, 8'hF5);
        @(negedge clk); pin_f = 8'hF0;
        settle(6);
        chk("R3 level follows pin", irq_f, 8'h00);
        @(negedge clk); pin_f = 8'h00;
        settle(6);
        wr(F + EN, 8'h00);
    endtask

    task automatic t_edge();
        logic [7:0] v;
        wr(A + MODE, 8'hFF); wr(A + POL, 8'h01);
        @(negedge clk); pin_a = 8'h02;
        settle(6);
        wr(A + ACK, 8'hFF); wr(A + EN, 8'h03);
        rd(A + STAT, v); chk("R4 idle edge status", v, 8'h00);
        @(negedge clk); pin_a = 8'h01;
        settle(6);
        rd(A + STAT, v); chk("R4 rise and fall latched", v, 8'h03);
        chk("R9 irq_ab from A", {7'd0, irq_ab}, 8'h01);
        @(negedge clk); pin_a = 8'h02;
        settle(6);
        rd(A + STAT, v); chk("R4 latch sticky", v, 8'h03);
    endtask

    task automatic t_ack();
        logic [7:0] v;
        wr(A + ACK, 8'h01);
        rd(A + STAT, v); chk("R5 selective ack", v, 8'h02);
        wr(A + ACK, 8'h00);
        rd(A + STAT, v); chk("R5 zero bits no effect", v, 8'h02);
        wr(A + ACK, 8'h02);
        rd(A + STAT, v); chk("R5 all cleared", v, 8'h00);
        chk("R5 irq_ab low", {7'd0, irq_ab}, 8'h00);
    endtask

    task automatic t_cfg_change();
        logic [7:0] v;
        wr(A + POL, 8'hFF); wr(A + MODE, 8'h00); wr(A + MODE, 8'hFF);
        wr(A + POL, 8'h00); wr(A + POL, 8'hFF);
        settle(4);
        rd(A + STAT, v); chk("R6 no latch from config", v, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        wr(A + EN, 8'h00);
        @(negedge clk); pin_a = 8'h03;
        settle(6);
        rd(A + STAT, v); chk("R7 masked status", v, 8'h00);
        chk("R7 masked irq_ab", {7'd0, irq_ab}, 8'h00);
        wr(A + EN, 8'h01);
        rd(A + STAT, v); chk("R7 latch kept", v, 8'h01);
        quiet_all();
        @(negedge clk); pin_a = 8'h00;
        settle(6);
        wr(A + ACK, 8'hFF);
    endtask

    task automatic pulse_f(input logic [7:0] m, input int n);
        @(negedge clk); pin_f = pin_f | m;
        repeat (n) @(posedge clk);
        @(negedge clk); pin_f = pin_f & ~m;
    endtask

    task automatic t_filter();
        logic [7:0] v;
        wr(F + MODE, 8'h04); wr(F + POL, 8'h04);
        wr(F + FILT, 8'h04); wr(F + EN, 8'h04);
        settle(8);
        wr(F + ACK, 8'hFF);
        pulse_f(8'h04, 3);
        settle(12);
        rd(F + STAT, v); chk("R8 3-cycle pulse rejected", v, 8'h00);
        pulse_f(8'h04, 8);
        settle(12);
        rd(F + STAT, v); chk("R8 8-cycle pulse accepted", v, 8'h04);
        chk("R9 irq_f own pin", irq_f, 8'h04);
        wr(F + ACK, 8'h04);
        wr(F + FILT, 8'h00);
        settle(8);
        pulse_f(8'h04, 1);
        settle(8);
        rd(F + STAT, v); chk("R8 unfiltered 1-cycle pulse", v, 8'h04);
        quiet_all();
        wr(F + MODE, 8'h00); wr(F + POL, 8'h00);
    endtask

    task automatic t_lines();
        logic [7:0] v;
        wr(B + MODE, 8'h00); wr(B + POL, 8'h80); wr(B + EN, 8'h80);
        @(negedge clk); pin_b = 8'h80;
        settle(6);
        rd(B + STAT, v); chk("R9 B status", v, 8'h80);
        chk("R9 irq_ab from B", {7'd0, irq_ab}, 8'h01);
        chk("R9 irq_f unaffected by B", irq_f, 8'h00);
        wr(F + POL, 8'hFF); wr(F + EN, 8'h10);
        @(negedge clk); pin_f = 8'h10;
        settle(6);
        chk("R9 irq_f single pin", irq_f, 8'h10);
        @(negedge clk); pin_b = 8'h00;
        settle(6);
        chk("R9 irq_ab drops", {7'd0, irq_ab}, 8'h00);
        chk("R9 irq_f holds", irq_f, 8'h10);
    endtask

    initial begin
        settle(4);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_level();
        t_edge();
        t_ack();
        t_cfg_change();
        t_mask();
        t_filter();
        t_lines();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule